// File: doc/BRIEF.md
# Multi-Port Pin Controller with Edge Interrupts

This block controls a bank of general-purpose pins. They are grouped into ports of eight lanes, and there are up to seven ports. A simple register bus reaches each port's state and configuration. Inside a port, every lane has its own 2-bit drive mode, an output data bit, a pull-up disable bit and interrupt settings. A pad-side interface returns the drive value, the output enable and the pull-up enable for each lane. Global pin number n sits on port n>>3 at lane n&7.

Pin inputs pass through two flops and then reach an edge detector. Each lane chooses which edge it watches. A detected edge sets a sticky event bit, and software clears that bit by writing a one to it. Each port has its own interrupt line. The line is high while any event bit that is also enabled is set, or while the port's force register is non-zero. A global control register holds a run bit. While the run bit is 0, sampling and edge detection are frozen. The same register also reports a version and the number of ports.

Top module: `pio_bank`

## Requirements
- R1: After reset, every lane is in input mode with output enable low and output data 0. All pull-ups are enabled, all interrupt enables and events are 0, every interrupt line is low, and the run bit is 0.
- R2: The global register at word address 0 reads back the version in bits 15:9, the port count in bits 8:2, and the run bit in bit 0. Writing bit 0 sets or clears the run bit. Read data appears on `bus_rdata` one clock after the read is accepted and is held until the next read.
- R3: Port p occupies the word addresses (p+1)*8 to (p+1)*8+7, and its lanes are global pins 8p to 8p+7. The offsets are: 0 synchronized pin level (read only), 1 output data, 2 mode, 3 pull-up disable, 4 interrupt enable, 5 edge select, 6 events, 7 interrupt force.
- R4: The mode of lane k sits in bits 2k+1:2k of the mode register. Code 00 is input, with output enable low. Code 01 is push-pull: the output is enabled and drives the data bit. Code 10 is open-drain: it drives 0 only while the data bit is 0. Code 11 is open-source: it drives 1 only while the data bit is 1.
- R5: A 1 in the pull-up disable register drives that lane's `pad_pu_en` low. A 0 drives it high.
- R6: Offset 0 returns the pin level after a two-flop synchronizer.
- R7: An edge-select bit of 1 latches rising edges and 0 latches falling edges. The opposite edge is ignored. The event bit is latched whatever the interrupt enable is, and it is visible three clocks after the pad changes.
- R8: Writing 1 to an event bit clears it, and writing 0 has no effect. When an edge arrives in the same cycle as the clear, the event stays set.
- R9: A port's interrupt line is high while (events AND enables) is non-zero, or while its force register is non-zero. Enable bits mask events from the line but do not change the events themselves.
- R10: While the run bit is 0, no new event is latched and the pin level read back holds its last value.
- R11: An event bit stays set until a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | NUM_PORTS*8 | Pin levels from the pads |
| pad_out | output | NUM_PORTS*8 | Value driven onto each pad |
| pad_oe | output | NUM_PORTS*8 | Pad output enable |
| pad_pu_en | output | NUM_PORTS*8 | Pad pull-up enable |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The bench targets four hard cases:
- A clear and a new edge landing on the same event bit in the same clock. A design that lets the clear win loses that interrupt.
- The edge that is not selected, and events on lanes whose interrupt is disabled. A wrong design either raises the line or forgets the event.
- The open-drain and open-source modes with both data values. A wrong design drives the pad in a state that must float.
- Pin changes while the run bit is 0. A design that does not freeze sampling latches events it should have missed.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned LANES = 8;
  localparam int unsigned REG_W = 16;
  localparam int unsigned OFF_W = 3;

  typedef enum logic [1:0] {
    PM_IN     = 2'b00,
    PM_PUSH   = 2'b01,
    PM_DRAIN  = 2'b10,
    PM_SOURCE = 2'b11
  } pin_mode_e;

  localparam logic [OFF_W-1:0] RG_PIN     = 3'd0;
  localparam logic [OFF_W-1:0] RG_DOUT    = 3'd1;
  localparam logic [OFF_W-1:0] RG_MODE    = 3'd2;
  localparam logic [OFF_W-1:0] RG_PULLDIS = 3'd3;
  localparam logic [OFF_W-1:0] RG_IEN     = 3'd4;
  localparam logic [OFF_W-1:0] RG_RSEL    = 3'd5;
  localparam logic [OFF_W-1:0] RG_EVENT   = 3'd6;
  localparam logic [OFF_W-1:0] RG_FORCE   = 3'd7;
endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  // sampling pipeline advances only while the block runs
  always_comb begin
    meta_d = meta_q;
    sync_d = sync_q;
    prev_d = prev_q;
    if (run_i) begin
      meta_d = pin_i;
      sync_d = meta_q;
      prev_d = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level_o = sync_q;
  assign hit_o   = {W{run_i}} &
                   ((rise_sel_i & sync_q & ~prev_q) |
                    (~rise_sel_i & ~sync_q & prev_q));
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [LANES-1:0]     hit_i,
  input  logic [LANES-1:0]     level_i,
  output logic [LANES-1:0]     rise_sel_o,
  output logic [LANES-1:0]     ev_o,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_o,
  output logic [LANES-1:0]     pad_out_o,
  output logic [LANES-1:0]     pad_oe_o,
  output logic [LANES-1:0]     pad_pu_en_o
);
  logic [LANES-1:0]   dout_q, pulldis_q, ien_q, rsel_q, event_q, force_q;
  logic [LANES-1:0]   dout_d, pulldis_d, ien_d, rsel_d, event_d, force_d;
  logic [2*LANES-1:0] mode_q, mode_d;
  logic [LANES-1:0]   clr_mask;
  logic               clr_wr;

  assign clr_wr = wr_i && (off_i == RG_EVENT);

  always_comb begin
    dout_d    = dout_q;
    mode_d    = mode_q;
    pulldis_d = pulldis_q;
    ien_d     = ien_q;
    rsel_d    = rsel_q;
    force_d   = force_q;
    if (wr_i) begin
      case (off_i)
        RG_DOUT:    dout_d    = wdata_i[LANES-1:0];
        RG_MODE:    mode_d    = wdata_i[2*LANES-1:0];
        RG_PULLDIS: pulldis_d = wdata_i[LANES-1:0];
        RG_IEN:     ien_d     = wdata_i[LANES-1:0];
        RG_RSEL:    rsel_d    = wdata_i[LANES-1:0];
        RG_FORCE:   force_d   = wdata_i[LANES-1:0];
        default:    ;
      endcase
    end
    clr_mask = clr_wr ? wdata_i[LANES-1:0] : '0;
    // a fresh edge outranks a clear of the same bit
    event_d  = (event_q & ~clr_mask) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      mode_q    <= '0;
      pulldis_q <= '0;
      ien_q     <= '0;
      rsel_q    <= '0;
      event_q   <= '0;
      force_q   <= '0;
    end else begin
      dout_q    <= dout_d;
      mode_q    <= mode_d;
      pulldis_q <= pulldis_d;
      ien_q     <= ien_d;
      rsel_q    <= rsel_d;
      event_q   <= event_d;
      force_q   <= force_d;
    end
  end

  always_comb begin
    case (off_i)
      RG_PIN:     rdata_o = {{(REG_W-LANES){1'b0}}, level_i};
      RG_DOUT:    rdata_o = {{(REG_W-LANES){1'b0}}, dout_q};
      RG_MODE:    rdata_o = mode_q;
      RG_PULLDIS: rdata_o = {{(REG_W-LANES){1'b0}}, pulldis_q};
      RG_IEN:     rdata_o = {{(REG_W-LANES){1'b0}}, ien_q};
      RG_RSEL:    rdata_o = {{(REG_W-LANES){1'b0}}, rsel_q};
      RG_EVENT:   rdata_o = {{(REG_W-LANES){1'b0}}, event_q};
      default:    rdata_o = {{(REG_W-LANES){1'b0}}, force_q};
    endcase
  end

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      pin_mode_e lane_mode;
      assign lane_mode = pin_mode_e'(mode_q[2*k+1:2*k]);
      always_comb begin
        case (lane_mode)
          PM_PUSH:   begin pad_oe_o[k] = 1'b1;       pad_out_o[k] = dout_q[k]; end
          PM_DRAIN:  begin pad_oe_o[k] = ~dout_q[k]; pad_out_o[k] = 1'b0;      end
          PM_SOURCE: begin pad_oe_o[k] = dout_q[k];  pad_out_o[k] = 1'b1;      end
          default:   begin pad_oe_o[k] = 1'b0;       pad_out_o[k] = 1'b0;      end
        endcase
      end

      // R4
      in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*k+1:2*k] == 2'b00) |-> !pad_oe_o[k]);
    end
  endgenerate

  assign pad_pu_en_o = ~pulldis_q;
  assign rise_sel_o  = rsel_q;
  assign ev_o        = event_q;
  assign irq_o       = (|(event_q & ien_q)) | (|force_q);

  // R11
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((event_q & $past(event_q)) == $past(event_q)));
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 7,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [6:0]  VERSION   = 7'd3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [REG_W-1:0]             bus_wdata,
  output logic [REG_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*LANES-1:0]   pad_in,
  output logic [NUM_PORTS*LANES-1:0]   pad_out,
  output logic [NUM_PORTS*LANES-1:0]   pad_oe,
  output logic [NUM_PORTS*LANES-1:0]   pad_pu_en,
  output logic [NUM_PORTS-1:0]         irq
);
  localparam int unsigned SLOT_W = ADDR_W - OFF_W;
  localparam logic [6:0]  CORES  = 7'(NUM_PORTS);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  off;
  logic              run_q, run_d;
  logic [REG_W-1:0]  rdata_q, rdata_d, rd_mux;
  logic [REG_W-1:0]  port_rd [NUM_PORTS];
  logic [LANES-1:0]  port_ev [NUM_PORTS];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign slot = bus_addr[ADDR_W-1:OFF_W];
  assign off  = bus_addr[OFF_W-1:0];

  always_comb begin
    run_d = run_q;
    if (bus_sel && bus_wr && (slot == '0)) run_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= run_d;
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      logic             wr_p;
      logic [LANES-1:0] level, hit, rsel;
      assign wr_p = bus_sel && bus_wr && (slot == SLOT_W'(p + 1));

      pio_sync_edge #(.W(LANES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .run_i     (run_q),
        .pin_i     (pad_in[p*LANES +: LANES]),
        .rise_sel_i(rsel),
        .level_o   (level),
        .hit_o     (hit)
      );

      pio_port_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .wr_i       (wr_p),
        .off_i      (off),
        .wdata_i    (bus_wdata),
        .hit_i      (hit),
        .level_i    (level),
        .rise_sel_o (rsel),
        .ev_o       (port_ev[p]),
        .rdata_o    (port_rd[p]),
        .irq_o      (irq[p]),
        .pad_out_o  (pad_out[p*LANES +: LANES]),
        .pad_oe_o   (pad_oe[p*LANES +: LANES]),
        .pad_pu_en_o(pad_pu_en[p*LANES +: LANES])
      );

      // R10
      frozen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !run_q |=> ((port_ev[p] & ~$past(port_ev[p])) == '0));
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (slot == '0) rd_mux = {VERSION, CORES, 1'b0, run_q};
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (slot == SLOT_W'(i + 1)) rd_mux = port_rd[i];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_sel && !bus_wr) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R2
  rd_ver_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && (slot == '0)) |=> (bus_rdata[15:2] == {VERSION, CORES}));
endmodule

// File: tb/pio_bank_tb_top.sv
`timescale 1ns/1ps
module pio_bank_tb_top;
  localparam int NP   = 7;
  localparam int AW   = 6;
  localparam int NPIN = NP * 8;
  localparam logic [15:0] CTRL_ID = 16'h061C;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [15:0]     bus_wdata, bus_rdata;
  logic [NPIN-1:0] pad_in, pad_out, pad_oe, pad_pu_en;
  logic [NP-1:0]   irq;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct { logic [15:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_pend;

  always #4 clk = ~clk;

  pio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu_en(pad_pu_en), .irq(irq)
  );

  always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

  // monitor: compares each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_pend === 1'b1) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expected item, actual %h", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [AW-1:0] adr(int port, int off);
    return AW'(((port + 1) << 3) | off);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [15:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads never returned", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 oe", 64'(pad_oe), 64'h0);
    chk("R1 pull-ups", 64'(pad_pu_en), {8'h0, {NPIN{1'b1}}});
    rd(adr(0, 1), 16'h0000, "R1 dout");
    rd(adr(6, 2), 16'h0000, "R1 mode");
    rd(adr(3, 4), 16'h0000, "R1 ien");
    rd(6'd0, CTRL_ID, "R2 ctrl at reset");

    // R2 run bit
    wr(6'd0, 16'h0001);
    rd(6'd0, CTRL_ID | 16'h0001, "R2 ctrl running");

    // R7 rising edge on pin 3 (port 0), R3 addressing
    wr(adr(0, 5), 16'h0008);
    wr(adr(0, 4), 16'h0008);
    @(negedge clk); pad_in[3] = 1'b1;
    wait_clks(3);
    chk("R7 rising edge irq", 64'(irq), 64'h1);
    rd(adr(0, 6), 16'h0008, "R7 event latched");

    // R7 opposite edge ignored, R11 sticky
    @(negedge clk); pad_in[3] = 1'b0;
    wait_clks(3);
    rd(adr(0, 6), 16'h0008, "R11 event held");
    wr(adr(0, 6), 16'h0000);
    rd(adr(0, 6), 16'h0008, "R8 write zero no effect");
    wr(adr(0, 6), 16'h0008);
    chk("R8 cleared irq", 64'(irq), 64'h0);
    rd(adr(0, 6), 16'h0000, "R8 event cleared");

    // R7 falling edge on pin 4, R9 masking
    @(negedge clk); pad_in[4] = 1'b1;
    wait_clks(3);
    @(negedge clk); pad_in[4] = 1'b0;
    wait_clks(3);
    chk("R9 masked event no irq", 64'(irq), 64'h0);
    rd(adr(0, 6), 16'h0010, "R7 falling event latched");
    wr(adr(0, 4), 16'h0018);
    chk("R9 unmasked irq", 64'(irq), 64'h1);
    wr(adr(0, 6), 16'h0010);
    chk("R9 irq after clear", 64'(irq), 64'h0);

    // R8 edge and clear in the same cycle
    @(negedge clk); pad_in[3] = 1'b1;
    wait_clks(3);
    @(negedge clk); pad_in[3] = 1'b0;
    wait_clks(3);
    @(negedge clk); pad_in[3] = 1'b1;
    @(negedge clk);
    wr(adr(0, 6), 16'h0008);
    rd(adr(0, 6), 16'h0008, "R8 edge wins over clear");
    chk("R8 irq after collision", 64'(irq), 64'h1);
    wr(adr(0, 6), 16'h0008);
    chk("R8 irq final clear", 64'(irq), 64'h0);

    // R4 modes: lane0 push-pull, lane1 open-drain, lane2 open-source, lane3 input
    wr(adr(0, 2), 16'h0039);
    chk("R4 oe dout=0", 64'(pad_oe[3:0]), 64'h3);
    chk("R4 out dout=0", 64'(pad_out[3:0] & pad_oe[3:0]), 64'h0);
    wr(adr(0, 1), 16'h0005);
    chk("R4 oe dout=05", 64'(pad_oe[3:0]), 64'h7);
    chk("R4 out dout=05", 64'(pad_out[3:0] & pad_oe[3:0]), 64'h5);
    wr(adr(0, 1), 16'h0002);
    chk("R4 oe dout=02", 64'(pad_oe[3:0]), 64'h1);
    chk("R4 out dout=02", 64'(pad_out[3:0] & pad_oe[3:0]), 64'h0);
    chk("R4 other ports float", 64'(pad_oe[NPIN-1:8]), 64'h0);

    // R5 pull-up disable on port 1
    wr(adr(1, 3), 16'h000F);
    chk("R5 port1 pull", 64'(pad_pu_en[15:8]), 64'hF0);
    chk("R5 port0 pull", 64'(pad_pu_en[7:0]), 64'hFF);

    // R6 level readback
    @(negedge clk); pad_in[23:16] = 8'hA5;
    wait_clks(3);
    rd(adr(2, 0), 16'h00A5, "R6 level port2");

    // R9 force on the last port
    wr(adr(6, 7), 16'h0001);
    chk("R9 forced irq", 64'(irq), 64'h40);
    wr(adr(6, 7), 16'h0000);
    chk("R9 force released", 64'(irq), 64'h0);

    // R10 freeze while not running
    wr(6'd0, 16'h0000);
    rd(6'd0, CTRL_ID, "R2 ctrl stopped");
    @(negedge clk); pad_in[23:16] = 8'h5A;
    wait_clks(5);
    rd(adr(2, 0), 16'h00A5, "R10 level frozen");
    rd(adr(2, 6), 16'h0000, "R10 no events while stopped");
    @(negedge clk); pad_in[23:16] = 8'hA5;
    wr(6'd0, 16'h0001);
    wait_clks(4);
    rd(adr(2, 6), 16'h0000, "R10 no events after restart");
    chk("R10 irq quiet", 64'(irq), 64'h0);

    wait_clks(2);
    finish_run();
  end
endmodule